// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block is a small translation cache that sits between an address generator and memory. It turns a virtual page number into a physical page number. Every stored entry is compared against the presented page number in parallel. The same cycle returns a hit with the physical page, a permission fault, or a miss. Each entry carries read, write and execute rights, a user-access right and a dirty flag. A lookup is checked against these fields before it is allowed to hit.

A miss raises a request toward an external page table walker over a valid/ready channel. The request holds its page number steady until the walker accepts it; while it waits, further misses do not replace it. The walker answers with a fill over a valid/ready channel. The block takes the fill whenever it is not flushing, so `fill_ready` falls only in a flush cycle and the walker must then hold the fill and retry.

A fill goes to the slot chosen in this order:
- the entry that already holds the same page;
- otherwise the lowest-numbered free slot;
- otherwise the slot under a round-robin pointer.

Software that changes a mapping removes the stale copy with a single-page invalidate, or empties the whole buffer with a one-cycle flush.

Top module: `xlat_buffer`

## Requirements
- R1: With `lk_valid` high, a lookup whose page number matches a valid entry and whose access is permitted raises `lk_hit` in the same cycle and drives that entry's physical page on `lk_ppn`. `lk_ppn` is zero when `lk_hit` is low.
- R2: A lookup that neither hits nor faults is a miss. If no walk request is pending, or the pending one is accepted in that cycle, the next cycle shows `walk_req_valid` high with the missed page number on `walk_req_vpn`. While `walk_req_ready` is low the request and its page number stay unchanged, and later misses are not captured.
- R3: The access code on `lk_acc` is 00 read, 01 write, 10 execute, and 11 is always denied. The access faults when any of the following holds: the matching entry lacks the right for that access; `lk_user` is 1 and the entry is not user-accessible; or the code is 11. A fault raises `lk_fault` and never `lk_hit`, and it starts no walk request.
- R4: A permitted write that matches an entry whose dirty flag is clear is reported as a miss and raises a walk request. The same write after the entry has been refilled with the dirty flag set hits.
- R5: A cycle with `inv_valid` high removes the entry holding `inv_vpn`, and the removal is visible to the next lookup. Other entries are untouched.
- R6: A cycle with `flush` high empties every entry, so the next lookup of any page misses. `fill_ready` is low in that cycle.
- R7: An accepted fill is stored with the fill bit fields [4] read, [3] write, [2] execute, [1] user-accessible and [0] dirty. A fill of a page already present overwrites that entry. Otherwise the fill takes the lowest-numbered free slot.
- R8: When no slot is free and the page is not present, the fill replaces the slot under a round-robin pointer. The pointer starts at slot 0 after reset and steps by one, wrapping, only on such a replacement.
- R9: When a fill and an invalidate name the same page in the same cycle, the invalidate wins and no entry for that page remains.
- R10: With `lk_valid` low, `lk_hit` and `lk_fault` are low and no walk request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 10 execute |
| lk_user | input | 1 | 1 for a user-level access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Translation found but access denied |
| lk_ppn | output | PPN_W | Physical page number on a hit |
| walk_req_valid | output | 1 | Walk request pending |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | VPN_W | Page number to walk |
| fill_valid | input | 1 | Walker offers a translation |
| fill_ready | output | 1 | Block accepts the fill (low during flush) |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_perm | input | 5 | [4] read, [3] write, [2] execute, [1] user, [0] dirty |
| inv_valid | input | 1 | Invalidate one page this cycle |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush | input | 1 | Empty the whole buffer this cycle |

## Verification
The round-robin pointer is the hardest state to reach from the ports. It moves only once every slot is occupied, so the stimulus first flushes the buffer and fills all 32 slots with distinct pages. Two more fills are then shown to evict slots 0 and 1 in turn. The stimulus next frees a middle slot by invalidation and sends two more fills. The first lands in the freed slot. The second evicts slot 2, which shows that the pointer did not move on the free-slot fill. The dirty-write miss is reached by filling a writable page with its dirty flag clear, then refilling the same page with the flag set.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // bit order matches the fill_perm port: [4] rd .. [0] dirty
  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic usr;
    logic dirty;
  } perm_t;
endpackage

// File: rtl/xb_cam.sv
`timescale 1ns/1ps
// Parallel compare of one key against every stored tag.
module xb_cam #(
  parameter int N = 32,
  parameter int W = 20
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] tags_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end
endmodule

// File: rtl/xb_perm.sv
`timescale 1ns/1ps
// Rights check for a matched entry.
module xb_perm
  import xlat_pkg::*;
(
  input  perm_t       perm_i,
  input  logic [1:0]  acc_i,
  input  logic        user_i,
  output logic        deny_o,
  output logic        clean_wr_o
);
  acc_e acc;
  assign acc = acc_e'(acc_i);

  always_comb begin
    unique case (acc)
      ACC_READ:  deny_o = !perm_i.rd;
      ACC_WRITE: deny_o = !perm_i.wr;
      ACC_EXEC:  deny_o = !perm_i.ex;
      default:   deny_o = 1'b1;
    endcase
    if (user_i && !perm_i.usr) deny_o = 1'b1;
  end

  assign clean_wr_o = (acc == ACC_WRITE) && !perm_i.dirty;
endmodule

// File: rtl/xb_victim.sv
`timescale 1ns/1ps
// Slot choice for a fill of a new page: lowest free slot, else round-robin.
module xb_victim #(
  parameter  int N     = 32,
  localparam int PTR_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_i,
  input  logic             advance_i,
  output logic [PTR_W-1:0] idx_o,
  output logic             free_o
);
  logic [PTR_W-1:0] rr_q;
  logic [PTR_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = PTR_W'(i);
    end
  end

  assign free_o = ~&valid_i;
  assign idx_o  = free_o ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance_i) begin
      rr_q <= (rr_q == PTR_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xb_walkreq.sv
`timescale 1ns/1ps
// Single-entry walk request register with valid/ready output.
module xb_walkreq #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         miss_i,
  input  logic [W-1:0] key_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] vpn_o
);
  logic take;
  assign take = miss_i && (!valid_o || ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else if (take) begin
      valid_o <= 1'b1;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) vpn_o <= key_i;
  end
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter  int ENTRIES = 32,
  parameter  int VPN_W   = 20,
  parameter  int PPN_W   = 20,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [4:0]       fill_perm,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush
);
  // entry storage
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  perm_t [ENTRIES-1:0]            perm_q;

  // three compare ports: lookup, fill, invalidate
  logic [ENTRIES-1:0] lk_match, fill_match, inv_match;

  xb_cam #(.N(ENTRIES), .W(VPN_W)) i_cam_lk (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(lk_vpn),   .match_o(lk_match));
  xb_cam #(.N(ENTRIES), .W(VPN_W)) i_cam_fill (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(fill_vpn), .match_o(fill_match));
  xb_cam #(.N(ENTRIES), .W(VPN_W)) i_cam_inv (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(inv_vpn),  .match_o(inv_match));

  // ---------------- lookup path ----------------
  logic [PPN_W-1:0] sel_ppn;
  perm_t            sel_perm;
  logic             any_match, deny, clean_wr, miss;

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_ppn  = sel_ppn | ppn_q[i];
        sel_perm = perm_t'(sel_perm | perm_q[i]);
      end
    end
  end

  assign any_match = |lk_match;

  xb_perm i_perm (
    .perm_i(sel_perm), .acc_i(lk_acc), .user_i(lk_user),
    .deny_o(deny), .clean_wr_o(clean_wr));

  assign lk_fault = lk_valid && any_match && deny;
  assign lk_hit   = lk_valid && any_match && !deny && !clean_wr;
  assign lk_ppn   = lk_hit ? sel_ppn : '0;
  assign miss     = lk_valid && !lk_hit && !lk_fault;

  xb_walkreq #(.W(VPN_W)) i_req (
    .clk(clk), .rst_n(rst_n), .miss_i(miss), .key_i(lk_vpn),
    .ready_i(walk_req_ready), .valid_o(walk_req_valid), .vpn_o(walk_req_vpn));

  // ---------------- fill path ----------------
  logic             fill_fire, fill_do, fill_hit, vic_free, rr_adv;
  logic [IDX_W-1:0] vic_idx, hit_idx, fill_idx;
  logic [ENTRIES-1:0] fill_oh;

  assign fill_ready = !flush;
  assign fill_fire  = fill_valid && fill_ready;
  assign fill_do    = fill_fire && !(inv_valid && (inv_vpn == fill_vpn));
  assign fill_hit   = |fill_match;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign rr_adv = fill_do && !fill_hit && !vic_free;

  xb_victim #(.N(ENTRIES)) i_vic (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_q), .advance_i(rr_adv),
    .idx_o(vic_idx), .free_o(vic_free));

  assign fill_idx = fill_hit ? hit_idx : vic_idx;
  assign fill_oh  = fill_do ? ({{(ENTRIES-1){1'b0}}, 1'b1} << fill_idx) : '0;

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      valid_q <= (valid_q & ~(inv_valid ? inv_match : '0)) | fill_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[fill_idx]  <= fill_vpn;
      ppn_q[fill_idx]  <= fill_ppn;
      perm_q[fill_idx] <= perm_t'(fill_perm);
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
module xlat_buffer_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic             walk_req_valid,
  input logic             walk_req_ready,
  input logic [VPN_W-1:0] walk_req_vpn,
  input logic             fill_ready,
  input logic             inv_valid,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             flush
);
  p_hit_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  p_fault_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault && !walk_req_valid |=> !walk_req_valid);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_req_vpn));

  p_miss_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit && !lk_fault && !walk_req_valid
      |=> walk_req_valid && (walk_req_vpn == $past(lk_vpn)));

  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit && !lk_fault);

  p_flush_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  p_inv_gone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_vpn == $past(inv_vpn) && (lk_hit || lk_fault)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_fault);
endmodule

bind xlat_buffer xlat_buffer_chk #(.VPN_W(VPN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_hit(lk_hit), .lk_fault(lk_fault), .walk_req_valid(walk_req_valid),
  .walk_req_ready(walk_req_ready), .walk_req_vpn(walk_req_vpn),
  .fill_ready(fill_ready), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
  .flush(flush));

// File: tb/test_xlat_buffer.sv
`timescale 1ns/1ps
module test_xlat_buffer;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int NE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_user = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [1:0] lk_acc = 2'b00;
  logic lk_hit, lk_fault, walk_req_valid, fill_ready;
  logic [PW-1:0] lk_ppn;
  logic [VW-1:0] walk_req_vpn;
  logic walk_req_ready = 1'b0, fill_valid = 1'b0, inv_valid = 1'b0, flush = 1'b0;
  logic [VW-1:0] fill_vpn = '0, inv_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [4:0] fill_perm = '0;

  always #2 clk = ~clk;  // 250 MHz

  xlat_buffer i_xlat_buffer (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic hit; logic fault; logic [PW-1:0] ppn; string tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one-cycle lookup, expectation pushed to scoreboard
  task automatic look(input logic [VW-1:0] v, input logic [1:0] a, input logic u,
                      input logic eh, input logic ef, input logic [PW-1:0] ep,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_vpn = v; lk_acc = a; lk_user = u;
    e.hit = eh; e.fault = ef; e.ppn = eh ? ep : '0; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (lk_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        chk(1'b0, "scoreboard empty", 0, 1);
      end else begin
        e = sb.pop_front();
        chk({lk_hit, lk_fault, lk_ppn} == {e.hit, e.fault, e.ppn}, e.tag,
            {lk_hit, lk_fault, lk_ppn}, {e.hit, e.fault, e.ppn});
      end
    end
  end

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [4:0] pm);
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic inval(input logic [VW-1:0] v);
    @(posedge clk); #1;
    inv_valid = 1'b1; inv_vpn = v;
    @(posedge clk); #1;
    inv_valid = 1'b0;
  endtask

  task automatic clear_req();
    @(posedge clk); #1;
    walk_req_ready = 1'b1;
    @(posedge clk); #1;
    walk_req_ready = 1'b0;
  endtask

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!lk_hit && !lk_fault && !walk_req_valid && fill_ready, "reset R10",
        {lk_hit, lk_fault, walk_req_valid, fill_ready}, 4'b0001);

    // R10: idle lookup inputs ignored
    @(posedge clk); #1 lk_vpn = 20'h5; lk_acc = WR;
    @(negedge clk);
    chk(!lk_hit && !lk_fault, "R10 idle outputs", {lk_hit, lk_fault}, 0);
    @(negedge clk);
    chk(!walk_req_valid, "R10 no request", walk_req_valid, 0);

    // R2: miss raises and holds request
    look(20'h10, RD, 1'b0, 1'b0, 1'b0, '0, "R2 miss");
    @(negedge clk);
    chk(walk_req_valid && walk_req_vpn == 20'h10, "R2 request", walk_req_vpn, 20'h10);
    look(20'h11, RD, 1'b0, 1'b0, 1'b0, '0, "R2 second miss");
    @(negedge clk);
    chk(walk_req_valid && walk_req_vpn == 20'h10, "R2 held", walk_req_vpn, 20'h10);
    clear_req();
    @(negedge clk);
    chk(!walk_req_valid, "R2 accepted", walk_req_valid, 0);

    // R1/R4/R7: writable page, clean first
    fill(20'h10, 20'hABC, 5'b11110);
    look(20'h10, RD, 1'b0, 1'b1, 1'b0, 20'hABC, "R1 read hit");
    look(20'h10, EX, 1'b1, 1'b1, 1'b0, 20'hABC, "R1 user exec hit");
    look(20'h10, WR, 1'b0, 1'b0, 1'b0, '0, "R4 clean write miss");
    @(negedge clk);
    chk(walk_req_valid && walk_req_vpn == 20'h10, "R4 request", walk_req_vpn, 20'h10);
    clear_req();
    fill(20'h10, 20'hABD, 5'b11111);
    look(20'h10, WR, 1'b0, 1'b1, 1'b0, 20'hABD, "R4 R7 dirty write hit");

    // R3: supervisor read-only page
    fill(20'h20, 20'h22, 5'b10001);
    look(20'h20, RD, 1'b0, 1'b1, 1'b0, 20'h22, "R3 sup read hit");
    look(20'h20, RD, 1'b1, 1'b0, 1'b1, '0, "R3 user fault");
    look(20'h20, EX, 1'b0, 1'b0, 1'b1, '0, "R3 exec fault");
    look(20'h20, WR, 1'b0, 1'b0, 1'b1, '0, "R3 write fault");
    look(20'h20, 2'b11, 1'b0, 1'b0, 1'b1, '0, "R3 reserved fault");
    @(negedge clk);
    chk(!walk_req_valid, "R3 no request", walk_req_valid, 0);

    // R5: invalidate one page
    inval(20'h20);
    look(20'h20, RD, 1'b0, 1'b0, 1'b0, '0, "R5 invalidated");
    look(20'h10, RD, 1'b0, 1'b1, 1'b0, 20'hABD, "R5 other kept");
    clear_req();

    // R9: fill and invalidate same page
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_vpn = 20'h30; fill_ppn = 20'h33; fill_perm = 5'b11111;
    inv_valid = 1'b1; inv_vpn = 20'h30;
    @(posedge clk); #1;
    fill_valid = 1'b0; inv_valid = 1'b0;
    look(20'h30, RD, 1'b0, 1'b0, 1'b0, '0, "R9 invalidate wins");
    clear_req();

    // R6: flush
    @(posedge clk); #1 flush = 1'b1;
    @(negedge clk);
    chk(!fill_ready, "R6 fill stalled", fill_ready, 0);
    @(posedge clk); #1 flush = 1'b0;
    look(20'h10, RD, 1'b0, 1'b0, 1'b0, '0, "R6 flushed");
    clear_req();

    // R7/R8: fill all slots, then round-robin
    for (int i = 0; i < NE; i++) fill(20'h100 + VW'(i), PW'(i), 5'b10001);
    look(20'h105, RD, 1'b0, 1'b1, 1'b0, 20'h5, "R7 slot fill");
    fill(20'h200, 20'h200, 5'b10001);
    look(20'h100, RD, 1'b0, 1'b0, 1'b0, '0, "R8 slot0 evicted");
    look(20'h101, RD, 1'b0, 1'b1, 1'b0, 20'h1, "R8 slot1 kept");
    look(20'h200, RD, 1'b0, 1'b1, 1'b0, 20'h200, "R8 new page");
    fill(20'h201, 20'h201, 5'b10001);
    look(20'h101, RD, 1'b0, 1'b0, 1'b0, '0, "R8 slot1 evicted");
    look(20'h102, RD, 1'b0, 1'b1, 1'b0, 20'h2, "R8 slot2 kept");
    inval(20'h110);
    fill(20'h300, 20'h300, 5'b10001);
    look(20'h102, RD, 1'b0, 1'b1, 1'b0, 20'h2, "R7 free slot used first");
    fill(20'h301, 20'h301, 5'b10001);
    look(20'h102, RD, 1'b0, 1'b0, 1'b0, '0, "R8 pointer held then slot2");
    look(20'h103, RD, 1'b0, 1'b1, 1'b0, 20'h3, "R8 slot3 kept");
    look(20'h300, RD, 1'b0, 1'b1, 1'b0, 20'h300, "R7 freed slot holds page");

    repeat (2) @(posedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule